// File: doc/BRIEF.md
# Bus Beat Observer

This block watches the slave side of an AHB-Lite port and never drives the bus. It turns each accepted transfer beat into one output record on a stream that has only a valid strobe. A record holds the address, the transfer direction, size, burst type, protection bits and transfer type. It also holds the data word and the slave response.

Capture happens in two stages that follow the bus pipeline. When a beat is accepted in its address phase, the block stores its attributes in a single pending slot. At the next cycle the bus accepts, it adds the data word and the response from that cycle and emits the finished record. Each beat of a burst becomes its own record, so a downstream checker can compare the stream against a bus that only does single transfers.

Top module: `ahb_beat_observer`

## Requirements
- R1: While `rst_n` is low, `rec_valid` is 0. Reset takes effect asynchronously.
- R2: A beat is captured only on a rising edge where `bus_ready`, `bus_sel` and `bus_trans[1]` are all 1. The encodings are IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. IDLE, BUSY, or `bus_sel` low never produce a record.
- R3: On an edge where `bus_ready` is 0, nothing is captured or emitted, and the pending beat is held. It completes at the first later edge where `bus_ready` is 1, using the data present at that edge.
- R4: `rec_data` is taken from `bus_wdata` when the captured beat had `bus_write`=1. It is taken from `bus_rdata` when the captured beat had `bus_write`=0.
- R5: `rec_resp` is the value of `bus_resp` at the completing edge.
- R6: `rec_addr`, `rec_write`, `rec_size`, `rec_burst`, `rec_prot` and `rec_trans` equal the address-phase values present at the capturing edge.
- R7: `rec_valid` is high for exactly the one cycle that follows each completing edge. Beats that complete on consecutive edges give records in consecutive cycles.
- R8: When one edge both completes the pending beat and captures a new beat, both beats are reported in order and neither is lost.
- R9: A reset discards the pending beat, so the first accepted cycle after reset produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_sel | input | 1 | Slave select |
| bus_addr | input | ADDR_W | Address-phase address |
| bus_trans | input | 2 | Transfer type |
| bus_size | input | 3 | Transfer size |
| bus_burst | input | 3 | Burst type |
| bus_prot | input | 4 | Protection bits |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| bus_ready | input | 1 | Transfer accepted / data phase done |
| bus_resp | input | 1 | Slave response |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_addr | output | ADDR_W | Beat address |
| rec_write | output | 1 | Beat direction |
| rec_size | output | 3 | Beat size |
| rec_burst | output | 3 | Beat burst type |
| rec_prot | output | 4 | Beat protection bits |
| rec_trans | output | 2 | Beat transfer type |
| rec_data | output | DATA_W | Write or read data |
| rec_resp | output | 1 | Response at completion |

## Verification
A beat's attributes are stored at the rising edge of its address phase. The record is registered at the next rising edge where `bus_ready` is high, and it is visible in the cycle after that edge. Every check sets the inputs at a falling edge and lets exactly one rising edge pass. It then reads the outputs at the following falling edge, so each expected value is due in the very cycle it is compared. Stall cycles and reset are stepped the same way, with an expected "no record" for each cycle in which `rec_valid` must stay low.

// File: rtl/beat_obs_pkg.sv
package beat_obs_pkg;
  localparam int unsigned TRANS_W = 2;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 3;
  localparam int unsigned PROT_W  = 4;

  typedef struct packed {
    logic [TRANS_W-1:0] trans;
    logic [SIZE_W-1:0]  size;
    logic [BURST_W-1:0] burst;
    logic [PROT_W-1:0]  prot;
    logic               write;
  } beat_ctl_t;
endpackage

// File: rtl/beat_addr_stage.sv
module beat_addr_stage
  import beat_obs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  beat_ctl_t         ctl,
  output logic              pend_v,
  output logic [ADDR_W-1:0] pend_addr,
  output beat_ctl_t         pend_ctl
);
  logic take;
  logic pend_v_d;

  always_comb begin
    take     = ready & sel & ctl.trans[1];
    pend_v_d = ready ? take : pend_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= pend_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_ctl  <= '0;
    end else if (take) begin
      pend_addr <= addr;
      pend_ctl  <= ctl;
    end
  end
endmodule

// File: rtl/beat_data_stage.sv
module beat_data_stage
  import beat_obs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              pend_v,
  input  logic [ADDR_W-1:0] pend_addr,
  input  beat_ctl_t         pend_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic              resp,
  output logic              rec_v,
  output logic [ADDR_W-1:0] rec_addr,
  output beat_ctl_t         rec_ctl,
  output logic [DATA_W-1:0] rec_data,
  output logic              rec_resp
);
  logic              fire;
  logic [DATA_W-1:0] data_sel;

  always_comb begin
    fire     = ready & pend_v;
    data_sel = pend_ctl.write ? wdata : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_v <= 1'b0;
    else        rec_v <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_addr <= '0;
      rec_ctl  <= '0;
      rec_data <= '0;
      rec_resp <= 1'b0;
    end else if (fire) begin
      rec_addr <= pend_addr;
      rec_ctl  <= pend_ctl;
      rec_data <= data_sel;
      rec_resp <= resp;
    end
  end
endmodule

// File: rtl/ahb_beat_observer.sv
module ahb_beat_observer
  import beat_obs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic [2:0]        bus_size,
  input  logic [2:0]        bus_burst,
  input  logic [3:0]        bus_prot,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_resp,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              rec_write,
  output logic [2:0]        rec_size,
  output logic [2:0]        rec_burst,
  output logic [3:0]        rec_prot,
  output logic [1:0]        rec_trans,
  output logic [DATA_W-1:0] rec_data,
  output logic              rec_resp
);
  beat_ctl_t         in_ctl;
  beat_ctl_t         pend_ctl;
  beat_ctl_t         out_ctl;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;

  always_comb begin
    in_ctl.trans = bus_trans;
    in_ctl.size  = bus_size;
    in_ctl.burst = bus_burst;
    in_ctl.prot  = bus_prot;
    in_ctl.write = bus_write;
  end

  beat_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (bus_ready),
    .sel      (bus_sel),
    .addr     (bus_addr),
    .ctl      (in_ctl),
    .pend_v   (pend_v),
    .pend_addr(pend_addr),
    .pend_ctl (pend_ctl)
  );

  beat_data_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (bus_ready),
    .pend_v   (pend_v),
    .pend_addr(pend_addr),
    .pend_ctl (pend_ctl),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .resp     (bus_resp),
    .rec_v    (rec_valid),
    .rec_addr (rec_addr),
    .rec_ctl  (out_ctl),
    .rec_data (rec_data),
    .rec_resp (rec_resp)
  );

  always_comb begin
    rec_write = out_ctl.write;
    rec_size  = out_ctl.size;
    rec_burst = out_ctl.burst;
    rec_prot  = out_ctl.prot;
    rec_trans = out_ctl.trans;
  end
endmodule

// File: rtl/ahb_beat_observer_chk.sv
module ahb_beat_observer_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic [1:0]        bus_trans,
  input logic              bus_ready,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_resp,
  input logic              pend_v,
  input logic [ADDR_W-1:0] pend_addr,
  input logic              pend_wr,
  input logic              rec_valid,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [DATA_W-1:0] rec_data,
  input logic              rec_resp
);
  always_comb begin
    if (!rst_n) assert_idle_in_reset_R1: assert (rec_valid == 1'b0);
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_sel && bus_trans[1]) |=> pend_v);

  assert_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && !(bus_sel && bus_trans[1])) |=> !pend_v);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> ($stable(pend_v) && !rec_valid));

  assert_write_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v && pend_wr) |=> (rec_data == $past(bus_wdata)));

  assert_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v && !pend_wr) |=> (rec_data == $past(bus_rdata)));

  assert_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v) |=> (rec_resp == $past(bus_resp)));

  assert_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v) |=> (rec_addr == $past(pend_addr)));

  assert_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v) |=> rec_valid);

  assert_no_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ready && pend_v) |=> !rec_valid);

  assert_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && pend_v && bus_sel && bus_trans[1]) |=> (rec_valid && pend_v));
endmodule

bind ahb_beat_observer ahb_beat_observer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_trans(bus_trans),
  .bus_ready(bus_ready),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_resp (bus_resp),
  .pend_v   (pend_v),
  .pend_addr(pend_addr),
  .pend_wr  (pend_ctl.write),
  .rec_valid(rec_valid),
  .rec_addr (rec_addr),
  .rec_data (rec_data),
  .rec_resp (rec_resp)
);

// File: tb/sim_ahb_beat_observer.sv
module sim_ahb_beat_observer;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_size;
  logic [2:0]  bus_burst;
  logic [3:0]  bus_prot;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        bus_resp;
  logic        rec_valid;
  logic [31:0] rec_addr;
  logic        rec_write;
  logic [2:0]  rec_size;
  logic [2:0]  rec_burst;
  logic [3:0]  rec_prot;
  logic [1:0]  rec_trans;
  logic [31:0] rec_data;
  logic        rec_resp;

  int checks;
  int failures;
  bit done;

  ahb_beat_observer u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        sel;
    logic [1:0]  tr;
    logic        wr;
    logic        rdy;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        rsp;
    logic        ev;
    logic [31:0] ea;
    logic        ew;
    logic [31:0] ed;
    logic        er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'b10, 1'b1, 1'b1, 32'h100, 32'h0,    32'h0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b1, 2'b11, 1'b1, 1'b1, 32'h104, 32'hA1,   32'h77,  1'b0, 1'b1, 32'h100, 1'b1, 32'hA1, 1'b0},
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   32'hB2,   32'h0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b0, 2'b00, 1'b0, 1'b1, 32'h0,   32'hB3,   32'h0,   1'b0, 1'b1, 32'h104, 1'b1, 32'hB3, 1'b0},
    '{1'b1, 2'b10, 1'b0, 1'b1, 32'h200, 32'h0,    32'h0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b1, 2'b01, 1'b0, 1'b1, 32'h204, 32'hDEAD, 32'hC5,  1'b0, 1'b1, 32'h200, 1'b0, 32'hC5, 1'b0},
    '{1'b1, 2'b00, 1'b0, 1'b1, 32'h208, 32'h0,    32'hC6,  1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b0, 2'b10, 1'b0, 1'b1, 32'h300, 32'h0,    32'h0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b1, 2'b10, 1'b0, 1'b1, 32'h304, 32'h0,    32'h0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,  1'b0},
    '{1'b0, 2'b00, 1'b0, 1'b1, 32'h0,   32'h5,    32'hE9,  1'b1, 1'b1, 32'h304, 1'b0, 32'hE9, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] t, input logic w, input logic r,
                       input logic [31:0] a, input logic [31:0] wd, input logic [31:0] rd,
                       input logic rs);
    bus_sel = s; bus_trans = t; bus_write = w; bus_ready = r;
    bus_addr = a; bus_wdata = wd; bus_rdata = rd; bus_resp = rs;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(1'b0, 2'b00, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 1'b0);
    bus_size = 3'd0; bus_burst = 3'd0; bus_prot = 4'd0;
    @(negedge clk);
    chk("R1 valid in reset", {31'd0, rec_valid}, 32'd0);
    tick();
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].sel, VT[i].tr, VT[i].wr, VT[i].rdy, VT[i].addr, VT[i].wd, VT[i].rd, VT[i].rsp);
      tick();
      chk($sformatf("R7 row%0d valid", i), {31'd0, rec_valid}, {31'd0, VT[i].ev});
      if (VT[i].ev) begin
        chk($sformatf("R6 row%0d addr", i), rec_addr, VT[i].ea);
        chk($sformatf("R6 row%0d write", i), {31'd0, rec_write}, {31'd0, VT[i].ew});
        chk($sformatf("R4 row%0d data", i), rec_data, VT[i].ed);
        chk($sformatf("R5 row%0d resp", i), {31'd0, rec_resp}, {31'd0, VT[i].er});
      end
    end

    // R7 R8 R6: back-to-back burst beats with attributes
    bus_size = 3'd2; bus_burst = 3'd3; bus_prot = 4'h3;
    drive(1'b1, 2'b10, 1'b1, 1'b1, 32'h400, 32'h0, 32'h0, 1'b0);
    tick();
    chk("R2 burst first no record", {31'd0, rec_valid}, 32'd0);
    bus_prot = 4'h9;
    for (int b = 1; b <= 3; b++) begin
      drive(b < 3, b < 3 ? 2'b11 : 2'b00, 1'b1, 1'b1, 32'h400 + 32'(4 * b), 32'(b), 32'h0, 1'b0);
      tick();
      chk($sformatf("R7 beat%0d valid", b), {31'd0, rec_valid}, 32'd1);
      chk($sformatf("R8 beat%0d addr", b), rec_addr, 32'h400 + 32'(4 * (b - 1)));
      chk($sformatf("R4 beat%0d data", b), rec_data, 32'(b));
      chk($sformatf("R6 beat%0d trans", b), {30'd0, rec_trans}, b == 1 ? 32'd2 : 32'd3);
      chk($sformatf("R6 beat%0d size", b), {29'd0, rec_size}, 32'd2);
      chk($sformatf("R6 beat%0d burst", b), {29'd0, rec_burst}, 32'd3);
      chk($sformatf("R6 beat%0d prot", b), {28'd0, rec_prot}, b == 1 ? 32'h3 : 32'h9);
    end
    drive(1'b0, 2'b00, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 1'b0);
    tick();
    chk("R7 pulse ends", {31'd0, rec_valid}, 32'd0);

    // R3: long stall, data taken at the releasing edge
    drive(1'b1, 2'b10, 1'b0, 1'b1, 32'h600, 32'h0, 32'h0, 1'b0);
    tick();
    for (int s = 0; s < 3; s++) begin
      drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h700, 32'h0, 32'h100 + 32'(s), 1'b0);
      tick();
      chk($sformatf("R3 stall%0d quiet", s), {31'd0, rec_valid}, 32'd0);
    end
    drive(1'b0, 2'b00, 1'b0, 1'b1, 32'h0, 32'h0, 32'h1FF, 1'b0);
    tick();
    chk("R3 released valid", {31'd0, rec_valid}, 32'd1);
    chk("R3 released addr", rec_addr, 32'h600);
    chk("R3 released data", rec_data, 32'h1FF);
    tick();
    chk("R3 stalled capture ignored", {31'd0, rec_valid}, 32'd0);

    // R9: reset drops pending beat
    drive(1'b1, 2'b10, 1'b1, 1'b1, 32'h800, 32'h0, 32'h0, 1'b0);
    tick();
    rst_n = 1'b0;
    #1;
    chk("R1 async reset valid", {31'd0, rec_valid}, 32'd0);
    drive(1'b0, 2'b00, 1'b0, 1'b1, 32'h0, 32'hAB, 32'h0, 1'b0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R9 pending discarded", {31'd0, rec_valid}, 32'd0);
    tick();
    chk("R9 still quiet", {31'd0, rec_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule